// File: doc/BRIEF.md
# Single-Error-Correcting Protected Memory

This block is a small synchronous memory that keeps every 8-bit word together with four Hamming check bits, so each location holds a 12-bit codeword. When a write is accepted, the encoder builds the codeword and stores it. When a read is accepted, the stored codeword is decoded. The decoder recomputes the check bits from the fetched data bits and XORs them with the stored ones to form a 4-bit syndrome. From the syndrome it either passes the data through, repairs one flipped data bit, or reports that the word cannot be repaired.

Requests arrive on a valid/ready channel. Each request carries a write flag, an address and write data. Read results leave on a second valid/ready channel. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low only while a response is being held, that is while `rsp_valid` is high and `rsp_ready` is low. The response registers therefore never overflow, and a stalled consumer stalls writes as well as reads. The response payload holds still until the consumer takes it.

A plain test port XORs a 12-bit mask into any stored codeword. Tests use it to place errors at chosen codeword positions.

Top module: `hamming_sec_mem`

## Requirements
- R1: Codeword positions are numbered 1..12, and position p is stored in bit p-1 of the codeword. Check bits occupy positions 1, 2, 4 and 8. Data bits 0..7 occupy positions 3, 5, 6, 7, 9, 10, 11 and 12, in that order. Each check bit gives even parity over the data positions whose number shares its set bit, so the XOR of the position numbers of all set bits in a stored codeword is zero.
- R2: If the syndrome is zero, the response carries the stored data unchanged, with `rsp_corrected`=0 and `rsp_uncorrectable`=0.
- R3: If the syndrome has two or more bits set and its value is 12 or less, the data bit at that position is inverted before output, and `rsp_corrected`=1.
- R4: If the syndrome has exactly one bit set, a check bit was hit. The data is output unmodified, with `rsp_corrected`=1.
- R5: If the syndrome is 13, 14 or 15, the data is output unmodified, with `rsp_uncorrectable`=1 and `rsp_corrected`=0. The two flags are never high together.
- R6: An accepted read raises `rsp_valid` on the next clock edge, carrying that read's result. `rsp_valid` never rises without a read having been accepted on that edge.
- R7: While `rsp_valid`=1 and `rsp_ready`=0, the response data and flags hold stable and `req_ready`=0.
- R8: An accepted write updates the location on that edge. A read accepted on the next cycle returns the new data.
- R9: When `inj_valid`=1, `inj_mask` is XORed into the codeword at `inj_addr` on that edge. The fault persists: reads do not write the repaired word back.
- R10: If a write and an injection target the same address in the same cycle, the stored codeword is the encoded write data XOR the mask.
- R11: If a read and an injection target the same address in the same cycle, the read returns the codeword as it was before the injection. Later reads see the injected fault.
- R12: Reset clears `rsp_valid` and both flags, raises `req_ready`, and sets every location to the all-zero codeword, which reads back as data 0 with no error.
- R13: Whenever `rsp_valid`=0, both `rsp_corrected` and `rsp_uncorrectable` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Location addressed by the request |
| req_wdata | input | 8 | Data to store on a write |
| rsp_valid | output | 1 | Read result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_data | output | 8 | Data returned, repaired where possible |
| rsp_corrected | output | 1 | A single-bit error was found; the returned data is correct |
| rsp_uncorrectable | output | 1 | The syndrome names no valid position |
| inj_valid | input | 1 | Apply a fault this cycle |
| inj_addr | input | ADDR_W | Location to corrupt |
| inj_mask | input | 12 | Bits to flip; bit p-1 is codeword position p |

## Verification
Two functions of this block can act on the same location in the same cycle, and the bench provokes both collisions.

The first collision is a write and a fault injection on one address in one cycle. The bench drives both in the same half-period. It then reads the location and expects the decode of the encoded write data XOR the mask, so the data comes back repaired with the corrected flag set. If the write simply overwrote the fault, the data would be clean with no flag. If the fault landed on the old contents, the data would be stale.

The second collision is a read and an injection on one address in one cycle. The bench expects that read to be clean and a later read to be flagged as corrected.

// File: rtl/hsec_pkg.sv
package hsec_pkg;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned CHK_W  = 4;
  localparam int unsigned CW_W   = DATA_W + CHK_W;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [CHK_W-1:0]  synd_t;
  typedef logic [CW_W-1:0]   cw_t;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_CHECK  = 2'd1,
    ERR_DATA   = 2'd2,
    ERR_UNCORR = 2'd3
  } err_kind_e;

  // 1-based codeword position of data bit idx: the idx-th position that is
  // not a power of two.
  function automatic int unsigned data_pos(input int unsigned idx);
    int unsigned seen;
    int unsigned found;
    seen  = 0;
    found = 0;
    for (int unsigned p = 1; p <= CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (seen == idx) found = p;
        seen++;
      end
    end
    return found;
  endfunction

  // Data bits covered by the check bit at position 2**k.
  function automatic data_t check_cover(input int unsigned k);
    data_t m;
    m = '0;
    for (int unsigned i = 0; i < DATA_W; i++) begin
      if (((data_pos(i) >> k) & 1) != 0) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/hsec_encoder.sv
module hsec_encoder
  import hsec_pkg::*;
(
  input  data_t din,
  output cw_t   cw
);

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_data
    assign cw[data_pos(gi) - 1] = din[gi];
  end

  for (genvar gk = 0; gk < CHK_W; gk++) begin : g_chk
    assign cw[(1 << gk) - 1] = ^(din & check_cover(gk));
  end

endmodule

// File: rtl/hsec_decoder.sv
module hsec_decoder
  import hsec_pkg::*;
(
  input  cw_t       cw,
  output data_t     dout,
  output err_kind_e kind
);

  data_t raw;
  data_t flip;
  synd_t synd;

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_data
    assign raw[gi]  = cw[data_pos(gi) - 1];
    assign flip[gi] = (synd == CHK_W'(data_pos(gi)));
  end

  for (genvar gk = 0; gk < CHK_W; gk++) begin : g_synd
    assign synd[gk] = (^(raw & check_cover(gk))) ^ cw[(1 << gk) - 1];
  end

  always_comb begin
    dout = raw;
    kind = ERR_NONE;
    if (synd == '0) begin
      kind = ERR_NONE;
    end else if ($onehot(synd)) begin
      kind = ERR_CHECK;
    end else if (synd > CHK_W'(CW_W)) begin
      kind = ERR_UNCORR;
    end else begin
      kind = ERR_DATA;
      dout = raw ^ flip;
    end
  end

endmodule

// File: rtl/hsec_store.sv
module hsec_store
  import hsec_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  cw_t               wr_cw,
  input  logic              inj_en,
  input  logic [ADDR_W-1:0] inj_addr,
  input  cw_t               inj_mask,
  input  logic [ADDR_W-1:0] rd_addr,
  output cw_t               rd_cw
);

  cw_t words [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
    logic hit_w;
    logic hit_i;
    cw_t  ent_q;

    assign hit_w = wr_en  && (wr_addr  == ADDR_W'(gi));
    assign hit_i = inj_en && (inj_addr == ADDR_W'(gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (hit_w || hit_i) begin
        ent_q <= (hit_w ? wr_cw : ent_q) ^ (hit_i ? inj_mask : '0);
      end
    end

    assign words[gi] = ent_q;
  end

  assign rd_cw = words[rd_addr];

endmodule

// File: rtl/hamming_sec_mem.sv
module hamming_sec_mem
  import hsec_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_data,
  output logic              rsp_corrected,
  output logic              rsp_uncorrectable,
  input  logic              inj_valid,
  input  logic [ADDR_W-1:0] inj_addr,
  input  logic [11:0]       inj_mask
);

  logic      accept;
  logic      wr_fire;
  logic      rd_fire;
  cw_t       enc_cw;
  cw_t       fetched_cw;
  data_t     dec_data;
  err_kind_e dec_kind;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_fire   = accept && req_write;
  assign rd_fire   = accept && !req_write;

  hsec_encoder u_enc (
    .din (req_wdata),
    .cw  (enc_cw)
  );

  hsec_store #(.ADDR_W(ADDR_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_fire),
    .wr_addr  (req_addr),
    .wr_cw    (enc_cw),
    .inj_en   (inj_valid),
    .inj_addr (inj_addr),
    .inj_mask (inj_mask),
    .rd_addr  (req_addr),
    .rd_cw    (fetched_cw)
  );

  hsec_decoder u_dec (
    .cw   (fetched_cw),
    .dout (dec_data),
    .kind (dec_kind)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid         <= 1'b0;
      rsp_data          <= '0;
      rsp_corrected     <= 1'b0;
      rsp_uncorrectable <= 1'b0;
    end else if (rd_fire) begin
      rsp_valid         <= 1'b1;
      rsp_data          <= dec_data;
      rsp_corrected     <= (dec_kind == ERR_CHECK) || (dec_kind == ERR_DATA);
      rsp_uncorrectable <= (dec_kind == ERR_UNCORR);
    end else if (rsp_ready) begin
      rsp_valid         <= 1'b0;
      rsp_corrected     <= 1'b0;
      rsp_uncorrectable <= 1'b0;
    end
  end

endmodule

// File: rtl/hsec_checker.sv
module hsec_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_write,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_data,
  input logic       rsp_corrected,
  input logic       rsp_uncorrectable
);

  a_r7_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) &&
      $stable(rsp_corrected) && $stable(rsp_uncorrectable)));

  a_r7_stall_request: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  a_r6_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready && !req_write));

  a_r13_flags_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_corrected && !rsp_uncorrectable));

  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_corrected && rsp_uncorrectable));

endmodule

bind hamming_sec_mem hsec_checker u_chk (.*);

// File: tb/hamming_sec_mem_tb.sv
module hamming_sec_mem_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [7:0]  rsp_data;
  logic        rsp_corrected;
  logic        rsp_uncorrectable;
  logic        inj_valid = 1'b0;
  logic [3:0]  inj_addr = '0;
  logic [11:0] inj_mask = '0;

  int checks = 0;
  int errors = 0;
  logic [11:0] model [16];

  always #10 clk = ~clk;

  hamming_sec_mem #(.ADDR_W(4)) u_dut (.*);

  // {addr, data, fault mask}; mask bit p-1 flips codeword position p
  localparam int NV = 10;
  localparam logic [23:0] VEC [NV] = '{
    {4'h0, 8'h39, 12'h020},  // R3: position 6 (data bit 2)
    {4'h1, 8'h39, 12'h000},  // R2: clean
    {4'h2, 8'hC2, 12'h001},  // R4: position 1
    {4'h3, 8'hFF, 12'h080},  // R4: position 8
    {4'h4, 8'h00, 12'h801},  // R5: syndrome 13
    {4'h5, 8'h5A, 12'hC00},  // R3: double fault, syndrome 7
    {4'h6, 8'hA5, 12'h08A},  // R5: syndrome 14
    {4'h7, 8'h81, 12'h00F},  // R4: syndrome 4
    {4'h8, 8'h3C, 12'h803},  // R5: syndrome 15
    {4'h9, 8'h66, 12'h100}   // R3: position 9
  };

  function automatic logic is_chk_pos(input int p);
    return (p == 1) || (p == 2) || (p == 4) || (p == 8);
  endfunction

  // R1: XOR of positions of all set bits is zero
  function automatic logic [11:0] tb_encode(input logic [7:0] d);
    logic [11:0] cw;
    logic [3:0]  s;
    int          n;
    cw = '0; s = '0; n = 0;
    for (int p = 1; p <= 12; p++) begin
      if (!is_chk_pos(p)) begin
        cw[p-1] = d[n];
        if (d[n]) s = s ^ 4'(p);
        n++;
      end
    end
    cw[0] = s[0]; cw[1] = s[1]; cw[3] = s[2]; cw[7] = s[3];
    return cw;
  endfunction

  function automatic logic [7:0] tb_extract(input logic [11:0] cw);
    logic [7:0] d;
    int         n;
    d = '0; n = 0;
    for (int p = 1; p <= 12; p++) begin
      if (!is_chk_pos(p)) begin
        d[n] = cw[p-1];
        n++;
      end
    end
    return d;
  endfunction

  task automatic tb_expect(input logic [11:0] cw, output logic [7:0] d,
                           output logic c, output logic u);
    logic [3:0]  s;
    logic [11:0] fixed;
    s = '0;
    for (int p = 1; p <= 12; p++) if (cw[p-1]) s = s ^ 4'(p);
    fixed = cw; c = 1'b0; u = 1'b0;
    if (s == 0) begin
    end else if (s > 12) begin
      u = 1'b1;
    end else begin
      c = 1'b1;
      if (!is_chk_pos(int'(s))) fixed[s-1] = ~fixed[s-1];
    end
    d = tb_extract(fixed);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    model[a] = tb_encode(d);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic do_inject(input logic [3:0] a, input logic [11:0] m);
    @(negedge clk);
    inj_valid = 1'b1; inj_addr = a; inj_mask = m;
    @(posedge clk);
    model[a] = model[a] ^ m;
    @(negedge clk);
    inj_valid = 1'b0; inj_mask = '0;
  endtask

  // read and compare with the model's prediction
  task automatic read_check(input logic [3:0] a, input string req);
    logic [7:0] ed;
    logic       ec, eu;
    tb_expect(model[a], ed, ec, eu);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    #1;
    check({req, " valid"}, 32'(rsp_valid), 32'd1);
    check({req, " data"}, 32'(rsp_data), 32'(ed));
    check({req, " corrected"}, 32'(rsp_corrected), 32'(ec));
    check({req, " uncorrectable"}, 32'(rsp_uncorrectable), 32'(eu));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R6 watchdog actual=hung expected=complete");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R12: reset state
    check("R12 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    check("R12 req_ready after reset", 32'(req_ready), 32'd1);
    check("R13 flags after reset", 32'({rsp_corrected, rsp_uncorrectable}), 32'd0);
    read_check(4'hF, "R12 cleared location");
    check("R12 cleared data", 32'(rsp_data), 32'd0);

    // table of vectors: write, fault, read (R1 R2 R3 R4 R5 R8 R9)
    for (int v = 0; v < NV; v++) begin
      do_write(VEC[v][23:20], VEC[v][19:12]);
      if (VEC[v][11:0] != '0) do_inject(VEC[v][23:20], VEC[v][11:0]);
      read_check(VEC[v][23:20], "R2 R3 R4 R5 vector");
    end
    // fixed example: data 0x39 with position 6 flipped returns 0x39
    read_check(4'h0, "R9 fault persists");
    check("R3 worked example", 32'(rsp_data), 32'h39);
    check("R3 worked example flag", 32'(rsp_corrected), 32'd1);

    // R1: every single position is repaired
    for (int p = 1; p <= 12; p++) begin
      do_write(4'hB, 8'h4B);
      do_inject(4'hB, 12'(1) << (p - 1));
      read_check(4'hB, "R1 single position");
      check("R1 single position repaired", 32'(rsp_data), 32'h4B);
    end

    // R8: overwrite then read back at once
    do_write(4'hA, 8'hE7);
    read_check(4'hA, "R8 read after write");
    check("R8 new data", 32'(rsp_data), 32'hE7);

    // R10: write and fault on the same address, same cycle
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 4'hC; req_wdata = 8'h96;
    inj_valid = 1'b1; inj_addr = 4'hC; inj_mask = 12'h010;
    @(posedge clk);
    model[4'hC] = tb_encode(8'h96) ^ 12'h010;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; inj_valid = 1'b0; inj_mask = '0;
    read_check(4'hC, "R10 write with fault");
    check("R10 fault kept", 32'(rsp_corrected), 32'd1);

    // R11: read and fault on the same address, same cycle
    do_write(4'hD, 8'h11);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 4'hD;
    inj_valid = 1'b1; inj_addr = 4'hD; inj_mask = 12'h040;
    @(posedge clk);
    #1;
    check("R11 old word data", 32'(rsp_data), 32'h11);
    check("R11 old word clean", 32'(rsp_corrected), 32'd0);
    model[4'hD] = model[4'hD] ^ 12'h040;
    @(negedge clk);
    req_valid = 1'b0; inj_valid = 1'b0; inj_mask = '0;
    read_check(4'hD, "R11 later read");
    check("R11 later read flagged", 32'(rsp_corrected), 32'd1);

    // R7: back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    read_check(4'h1, "R7 first response");
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 4'h0;
    #1;
    check("R7 req_ready low while held", 32'(req_ready), 32'd0);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      #1;
      check("R7 held valid", 32'(rsp_valid), 32'd1);
      check("R7 held data", 32'(rsp_data), 32'h39);
      check("R7 held flag", 32'(rsp_corrected), 32'd0);
    end
    @(negedge clk);
    rsp_ready = 1'b1;
    @(posedge clk);
    #1;
    check("R6 next read data", 32'(rsp_data), 32'h39);
    check("R6 next read flag", 32'(rsp_corrected), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    #1;
    check("R13 drained valid", 32'(rsp_valid), 32'd0);
    check("R13 drained flags", 32'({rsp_corrected, rsp_uncorrectable}), 32'd0);

    // R5 flag clears after an uncorrectable response drains
    read_check(4'h4, "R5 uncorrectable again");
    @(posedge clk);
    #1;
    check("R13 uncorrectable cleared", 32'(rsp_uncorrectable), 32'd0);

    // R12: reset mid-run clears storage
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) model[i] = '0;
    read_check(4'h0, "R12 location cleared by reset");
    check("R12 cleared word", 32'(rsp_data), 32'd0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule